// File: doc/BRIEF.md
# Dual-Field Array Multiplier

This block multiplies two unsigned operands of parameterised width in one of two arithmetic systems: ordinary integer multiplication, or carry-less multiplication of binary polynomials (coefficients in GF(2)). Both products come from one partial-product array. Each cell forms its partial-product bit with an AND gate and adds it into a running sum through a full adder whose carry output is gated by an enable. When the enable is high the array is an ordinary ripple-row multiplier. When it is low no carry ever leaves a cell, so each sum bit is the XOR of the partial products in its column, which is exactly the polynomial product.

A single field-select input picks the mode. The operands and the mode are sampled together on a rising clock edge, and the full double-width product is held in an output register from that edge on. Accumulation, modular reduction and sequencing belong to the surrounding datapath.

Top module: `dfmul_top`

## Requirements
- R1: While `rst` is high at a rising edge, `product` is all zeros after that edge.
- R2: With `field_sel` = 0 (integer field) at a rising edge where `rst` is low, `product` after that edge equals the unsigned integer product of `op_a` and `op_b`, with `op_a` and `op_b` each taken as W-bit unsigned values.
- R3: With `field_sel` = 1 (binary-polynomial field) at a rising edge where `rst` is low, `product` after that edge equals the carry-less product: bit k is the XOR over all i+j=k of `op_a[i]` AND `op_b[j]`, for k from 0 to 2W-2.
- R4: In binary-polynomial mode the most significant product bit, bit 2W-1, is zero for every operand pair.
- R5: Mode is taken per sample: alternating `field_sel` on consecutive edges gives, after each edge, the product for the mode and operands of that edge only.
- R6: A zero operand gives a zero product in both modes.
- R7: An operand of value one gives the other operand, zero-extended to 2W bits, in both modes.
- R8: All-ones operands give (2^W-1)^2 in integer mode, and in polynomial mode give bit k set exactly when the number of (i,j) pairs with i+j=k is odd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | W | Multiplicand |
| op_b | input | W | Multiplier |
| field_sel | input | 1 | 0 = integer product, 1 = carry-less polynomial product |
| product | output | 2W | Registered double-width product |

## Verification
The all-ones operands are the hardest case: in integer mode every carry chain is fully exercised, so a cell whose carry escapes the enable in polynomial mode, or a lost top carry out of a row, shows up as a wrong high half, while in polynomial mode the alternating column parity pattern exposes any leaked carry. The top bit is watched in polynomial mode because a leaking carry is the only way it could be set. Mode is switched on every cycle with changing operands, so a design that registered the mode one cycle off from the operands would return the other field's product. Zero and unit operands catch a swapped or shifted row, which would move the single surviving row to the wrong place.

// File: rtl/dfmul_pkg.sv
package dfmul_pkg;

    typedef enum logic {
        FIELD_INT  = 1'b0,
        FIELD_POLY = 1'b1
    } field_e;

    typedef struct packed {
        logic sum;
        logic carry;
    } cell_out_t;

    function automatic logic carries_enabled(field_e f);
        return (f == FIELD_INT);
    endfunction

    function automatic cell_out_t gated_full_add(logic x, logic y, logic cin, logic en);
        cell_out_t r;
        r.sum   = x ^ y ^ cin;
        r.carry = en & ((x & y) | (x & cin) | (y & cin));
        return r;
    endfunction

endpackage

// File: rtl/dfmul_cell.sv
module dfmul_cell
    import dfmul_pkg::*;
(
    input  logic a_bit,
    input  logic b_bit,
    input  logic sum_in,
    input  logic carry_in,
    input  logic carry_en,
    output logic sum_out,
    output logic carry_out
);
    logic      pp;
    cell_out_t fa;

    assign pp        = a_bit & b_bit;
    assign fa        = gated_full_add(pp, sum_in, carry_in, carry_en);
    assign sum_out   = fa.sum;
    assign carry_out = fa.carry;
endmodule

// File: rtl/dfmul_row.sv
module dfmul_row #(
    parameter int W   = 16,
    parameter int ROW = 0
) (
    input  logic [W-1:0]   a,
    input  logic           b_bit,
    input  logic           carry_en,
    input  logic [2*W-1:0] acc_in,
    output logic [2*W-1:0] acc_out
);
    localparam int PW = 2 * W;

    logic [W:0]   chain;
    logic [W-1:0] sums;

    assign chain[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_cell
        dfmul_cell u_cell (
            .a_bit    (a[i]),
            .b_bit    (b_bit),
            .sum_in   (acc_in[ROW+i]),
            .carry_in (chain[i]),
            .carry_en (carry_en),
            .sum_out  (sums[i]),
            .carry_out(chain[i+1])
        );
    end

    always_comb begin
        acc_out          = acc_in;
        acc_out[ROW +: W] = sums;
        if (ROW + W < PW) begin
            acc_out[ROW+W] = chain[W];
        end
    end
endmodule

// File: rtl/dfmul_array.sv
module dfmul_array #(
    parameter int W = 16
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           carry_en,
    output logic [2*W-1:0] prod
);
    localparam int PW = 2 * W;

    logic [PW-1:0] stage [W+1];

    assign stage[0] = '0;

    for (genvar j = 0; j < W; j++) begin : g_row
        dfmul_row #(.W(W), .ROW(j)) u_row (
            .a       (a),
            .b_bit   (b[j]),
            .carry_en(carry_en),
            .acc_in  (stage[j]),
            .acc_out (stage[j+1])
        );
    end

    assign prod = stage[W];
endmodule

// File: rtl/dfmul_top.sv
module dfmul_top
    import dfmul_pkg::*;
#(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [W-1:0]   op_a,
    input  logic [W-1:0]   op_b,
    input  logic           field_sel,
    output logic [2*W-1:0] product
);
    localparam int PW = 2 * W;

    field_e        field;
    logic          carry_en;
    logic [PW-1:0] prod_comb;

    assign field    = field_e'(field_sel);
    assign carry_en = carries_enabled(field);

    dfmul_array #(.W(W)) u_array (
        .a       (op_a),
        .b       (op_b),
        .carry_en(carry_en),
        .prod    (prod_comb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            product <= '0;
        end else begin
            product <= prod_comb;
        end
    end
endmodule

// File: rtl/dfmul_checker.sv
module dfmul_checker #(
    parameter int W = 16
) (
    input logic           clk,
    input logic           rst,
    input logic [W-1:0]   op_a,
    input logic [W-1:0]   op_b,
    input logic           field_sel,
    input logic [2*W-1:0] product
);
    localparam int PW = 2 * W;

    logic          armed;
    logic [W-1:0]  a_q;
    logic [W-1:0]  b_q;
    logic          sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            a_q   <= '0;
            b_q   <= '0;
            sel_q <= 1'b0;
        end else begin
            armed <= 1'b1;
            a_q   <= op_a;
            b_q   <= op_b;
            sel_q <= field_sel;
        end
    end

    function automatic logic [PW-1:0] ref_clmul(logic [W-1:0] x, logic [W-1:0] y);
        logic [PW-1:0] acc;
        acc = '0;
        for (int k = 0; k < W; k++) begin
            if (y[k]) acc = acc ^ (PW'(x) << k);
        end
        return acc;
    endfunction

    logic [PW-1:0] int_ref;
    assign int_ref = PW'(a_q) * PW'(b_q);

    p_reset_clear_r1: assert property (@(posedge clk) rst |=> product == '0);

    p_int_product_r2: assert property (@(posedge clk) disable iff (rst)
        (armed && !sel_q) |-> product == int_ref);

    p_poly_product_r3: assert property (@(posedge clk) disable iff (rst)
        (armed && sel_q) |-> product == ref_clmul(a_q, b_q));

    p_poly_top_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (armed && sel_q) |-> !product[PW-1]);

    p_zero_operand_r6: assert property (@(posedge clk) disable iff (rst)
        (armed && (a_q == '0 || b_q == '0)) |-> product == '0);
endmodule

bind dfmul_top dfmul_checker #(.W(W)) u_dfmul_checker (
    .clk      (clk),
    .rst      (rst),
    .op_a     (op_a),
    .op_b     (op_b),
    .field_sel(field_sel),
    .product  (product)
);

// File: tb/dfmul_top_bench.sv
module dfmul_top_bench;
    localparam int W  = 16;
    localparam int PW = 2 * W;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [W-1:0]  op_a = '0;
    logic [W-1:0]  op_b = '0;
    logic          field_sel = 1'b0;
    logic [PW-1:0] product;

    int checks = 0;
    int failures = 0;
    logic [31:0] seed = 32'h1234_5679;

    always #5 clk = ~clk;

    dfmul_top #(.W(W)) u_dfmul_top (
        .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b),
        .field_sel(field_sel), .product(product)
    );

    function automatic logic [PW-1:0] exp_int(logic [W-1:0] x, logic [W-1:0] y);
        logic [PW-1:0] xx, yy;
        xx = {{W{1'b0}}, x};
        yy = {{W{1'b0}}, y};
        return xx * yy;
    endfunction

    function automatic logic [PW-1:0] exp_poly(logic [W-1:0] x, logic [W-1:0] y);
        logic [PW-1:0] r;
        r = '0;
        for (int i = 0; i < W; i++)
            for (int j = 0; j < W; j++)
                r[i+j] = r[i+j] ^ (x[i] & y[j]);
        return r;
    endfunction

    function automatic logic [W-1:0] next_rand();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed[W-1:0];
    endfunction

    task automatic check(string req, logic [PW-1:0] act, logic [PW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at negedge, sample at the following negedge (one register)
    task automatic apply_and_check(string req, logic [W-1:0] a, logic [W-1:0] b, logic sel);
        @(negedge clk);
        op_a = a; op_b = b; field_sel = sel;
        @(negedge clk);
        check(req, product, sel ? exp_poly(a, b) : exp_int(a, b));
    endtask

    task automatic t_reset();
        rst = 1'b1;
        op_a = 16'hFFFF; op_b = 16'hFFFF; field_sel = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 reset", product, '0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_integer();
        apply_and_check("R2 int", 16'h0003, 16'h0005, 1'b0);
        apply_and_check("R2 int", 16'h1234, 16'h5678, 1'b0);
        apply_and_check("R2 int", 16'h8000, 16'h8000, 1'b0);
        for (int n = 0; n < 20; n++) apply_and_check("R2 int rand", next_rand(), next_rand(), 1'b0);
    endtask

    task automatic t_poly();
        apply_and_check("R3 poly", 16'h0003, 16'h0003, 1'b1);
        apply_and_check("R3 poly", 16'h1234, 16'h5678, 1'b1);
        apply_and_check("R3 poly", 16'h8001, 16'h8003, 1'b1);
        for (int n = 0; n < 20; n++) apply_and_check("R3 poly rand", next_rand(), next_rand(), 1'b1);
    endtask

    task automatic t_poly_msb();
        @(negedge clk);
        op_a = 16'h8000; op_b = 16'hFFFF; field_sel = 1'b1;
        @(negedge clk);
        check("R4 poly msb", {{(PW-1){1'b0}}, product[PW-1]}, '0);
        op_a = 16'hFFFF; op_b = 16'hFFFF;
        @(negedge clk);
        check("R4 poly msb all ones", {{(PW-1){1'b0}}, product[PW-1]}, '0);
    endtask

    task automatic t_mode_switch();
        logic [W-1:0] pa, pb;
        logic         ps;
        pa = 16'hBEEF; pb = 16'hCAFE; ps = 1'b0;
        @(negedge clk);
        op_a = pa; op_b = pb; field_sel = ps;
        for (int n = 0; n < 12; n++) begin
            @(negedge clk);
            check("R5 mode switch", product, ps ? exp_poly(pa, pb) : exp_int(pa, pb));
            pa = next_rand(); pb = next_rand(); ps = ~ps;
            op_a = pa; op_b = pb; field_sel = ps;
        end
        @(negedge clk);
        check("R5 mode switch last", product, ps ? exp_poly(pa, pb) : exp_int(pa, pb));
    endtask

    task automatic t_zero_one();
        apply_and_check("R6 zero int", 16'h0000, 16'hA5A5, 1'b0);
        check("R6 zero int value", product, '0);
        apply_and_check("R6 zero poly", 16'hA5A5, 16'h0000, 1'b1);
        check("R6 zero poly value", product, '0);
        apply_and_check("R7 one int", 16'h0001, 16'hF00D, 1'b0);
        check("R7 one int value", product, 32'h0000_F00D);
        apply_and_check("R7 one poly", 16'hF00D, 16'h0001, 1'b1);
        check("R7 one poly value", product, 32'h0000_F00D);
    endtask

    task automatic t_all_ones();
        apply_and_check("R8 ones int", 16'hFFFF, 16'hFFFF, 1'b0);
        check("R8 ones int value", product, 32'hFFFE_0001);
        apply_and_check("R8 ones poly", 16'hFFFF, 16'hFFFF, 1'b1);
        check("R8 ones poly value", product, 32'h5555_5555);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_integer();
        t_poly();
        t_poly_msb();
        t_mode_switch();
        t_zero_one();
        t_all_ones();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule